// File: doc/BRIEF.md
# Clock-Gated Twisted-Ring Counter

This block is a twisted-ring counter whose storage stages are toggle flops with the toggle input tied high. A stage never takes a load each cycle. It changes state only in a cycle where its own clock enable is raised, and that enable is predicted from neighbouring stage outputs using XOR and XNOR terms. With the default of four stages, the counter passes through eight distinct codes before repeating. Each stage is enabled on only two of those eight edges, and every other master clock edge is suppressed for it.

The per-stage enables are driven out of the block, so switching activity can be observed or counted. The gating is modelled as a synthesizable clock enable on each flop, with no latch and no clock-tree cell. The block has a free-running clock, an active-low asynchronous reset, a synchronous clear and a global count enable.

Top module: `jc_gated_ring`

## Requirements
- R1: While `rst_ni` is low, every bit of `state_o` is 0, and it stays 0 until the first counting edge after reset is released.
- R2: With the count enable high and no clear, `state_o` steps through 2*NUM_STAGES codes and then repeats. For four stages the codes are 4'b0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, written `state_o[3:0]`. Stage 0 loads the inverse of stage NUM_STAGES-1, and stage i loads stage i-1.
- R3: In every cycle where the count enable is high and the clear is low, exactly one bit of `stage_en_o` is 1. That bit is the position of the single bit of `state_o` that changes on the next rising edge.
- R4: `stage_en_o[0]` is raised when `state_o[0]` equals `state_o[NUM_STAGES-1]`. `stage_en_o[i]` for i >= 1 is raised when `state_o[i]` differs from `state_o[i-1]`.
- R5: Over any 2*NUM_STAGES consecutive counting cycles, each stage enable is raised exactly twice. The enables are raised 2*NUM_STAGES times in total.
- R6: A stage changes only on an edge where its enable is high, and on that edge it inverts. On every other edge it holds.
- R7: While `cnt_en_i` is low, `stage_en_o` is all zeros and `state_o` holds its value.
- R8: `clr_i` high forces `state_o` to all zeros on the next rising edge, whatever the level of `cnt_en_i`. While `clr_i` is high, `stage_en_o` is all zeros.
- R9: `state_o` is always a legal code: at most one adjacent pair of stages, i and i-1, holds differing values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to the all-zero code |
| cnt_en_i | input | 1 | Global count enable |
| state_o | output | NUM_STAGES | Stage outputs, bit 0 is the first stage |
| stage_en_o | output | NUM_STAGES | Per-stage gated clock enables |

## Verification
The bench drives four kinds of stimulus: counting through the wrap from the all-ones code back to zero, idle cycles with the count enable low, a clear asserted together with the count enable, and reset asserted in the middle of a run.

Each kind targets a specific fault:
- A swapped XOR and XNOR on stage 0 would freeze the counter at zero or let it run into illegal codes.
- A wrong neighbour index would enable two stages at once, or none.
- An enable that ignores the global gate would keep advancing while idle.
- A clear with lower priority than counting would leave one stage set.

Per-stage enable counts over full revolutions catch a design that clocks a stage more often than its two changes need.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int unsigned JC_DEF_STAGES = 4;

  typedef enum logic {GATE_XNOR = 1'b0, GATE_XOR = 1'b1} gate_kind_e;

  // stage 0 closes the twist, so it compares against the last stage
  function automatic gate_kind_e kind_of(input int unsigned idx);
    return (idx == 0) ? GATE_XNOR : GATE_XOR;
  endfunction
endpackage

// File: rtl/jc_tff_stage.sv
module jc_tff_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgl_en_i,
  output logic q_o
);
  localparam logic T_IN = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (clr_i)    q_o <= 1'b0;
    else if (tgl_en_i) q_o <= q_o ^ T_IN;
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tgl_en_i) |=> $stable(q_o));
  assert_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tgl_en_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/jc_gate.sv
module jc_gate #(
  parameter int unsigned NUM_STAGES = jc_pkg::JC_DEF_STAGES
) (
  input  logic [NUM_STAGES-1:0] q_i,
  input  logic                  cnt_en_i,
  input  logic                  clr_i,
  output logic [NUM_STAGES-1:0] en_o
);
  logic run;
  assign run = cnt_en_i & ~clr_i;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_term
    if (jc_pkg::kind_of(i) == jc_pkg::GATE_XNOR) begin : g_xnor
      assign en_o[i] = run & ~(q_i[i] ^ q_i[NUM_STAGES-1]);
    end else begin : g_xor
      assign en_o[i] = run & (q_i[i] ^ q_i[i-1]);
    end
  end
endmodule

// File: rtl/jc_gated_ring.sv
module jc_gated_ring #(
  parameter int unsigned NUM_STAGES = jc_pkg::JC_DEF_STAGES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cnt_en_i,
  output logic [NUM_STAGES-1:0] state_o,
  output logic [NUM_STAGES-1:0] stage_en_o
);
  localparam int unsigned NB = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] q;
  logic [NUM_STAGES-1:0] en;
  logic [NB-1:0]         bnd;

  jc_gate #(.NUM_STAGES(NUM_STAGES)) u_gate (
    .q_i(q), .cnt_en_i(cnt_en_i), .clr_i(clr_i), .en_o(en)
  );

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stg
    jc_tff_stage u_stg (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .tgl_en_i(en[i]), .q_o(q[i])
    );
  end

  for (genvar i = 1; i < NUM_STAGES; i++) begin : g_bnd
    assign bnd[i-1] = q[i] ^ q[i-1];
  end

  assign state_o    = q;
  assign stage_en_o = en;

  assert_one_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !clr_i) |-> ($countones(stage_en_o) == 1));
  assert_one_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !clr_i) |=> ($countones(state_o ^ $past(state_o)) == 1));
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !clr_i) |=> $stable(state_o));
  assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_o == '0));
  assert_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(bnd) <= 1));
endmodule

// File: tb/tb_jc_gated_ring.sv
module tb_jc_gated_ring;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr = 1'b0;
  logic cnt_en = 1'b0;
  logic [N-1:0] state_o, stage_en_o;

  int total = 0;
  int bad = 0;
  logic [N-1:0] model = '0;
  int hits[N];
  bit done = 0;

  always #5 clk = ~clk;

  jc_gated_ring #(.NUM_STAGES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .cnt_en_i(cnt_en),
    .state_o(state_o), .stage_en_o(stage_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] shift_next(input logic [N-1:0] s);
    return {s[N-2:0], ~s[N-1]};
  endfunction

  task automatic step(input logic en, input logic c);
    logic [N-1:0] exp_en;
    @(negedge clk);
    cnt_en = en;
    clr = c;
    #1;
    exp_en = (en && !c) ? (shift_next(model) ^ model) : '0;
    chk((c ? "R8 en" : (en ? "R3/R4 en" : "R7 en")), stage_en_o, exp_en);
    if (en && !c)
      for (int b = 0; b < N; b++) if (stage_en_o[b]) hits[b]++;
    @(posedge clk);
    #1;
    model = c ? '0 : (en ? shift_next(model) : model);
    chk((c ? "R8 state" : (en ? "R2/R6 state" : "R7 state")), state_o, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < N; b++) hits[b] = 0;
    #12;
    chk("R1 reset state", state_o, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 hold after release", state_o, '0);

    // one full revolution, explicit code list
    begin
      logic [N-1:0] seq[8] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111,
                               4'b1110, 4'b1100, 4'b1000, 4'b0000};
      for (int k = 0; k < 2*N; k++) begin
        step(1'b1, 1'b0);
        chk("R2 sequence", state_o, seq[k]);
      end
    end
    begin
      int sum = 0;
      for (int b = 0; b < N; b++) begin
        chk("R5 per-stage enables", hits[b], 2);
        sum += hits[b];
        hits[b] = 0;
      end
      chk("R5 total enables", sum, 2*N);
    end

    // partial run, then idle (R7)
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0);
    // second revolution from a non-zero start, across the wrap
    for (int b = 0; b < N; b++) hits[b] = 0;
    for (int k = 0; k < 2*N; k++) step(1'b1, 1'b0);
    for (int b = 0; b < N; b++) chk("R5 enables mid start", hits[b], 2);
    chk("R9 legal code", ($countones(state_o ^ {state_o[N-2:0], state_o[N-1]}) <= 2), 1);

    // clear with count enable high (R8 priority)
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R8 cleared", state_o, '0);
    step(1'b0, 1'b1);
    for (int k = 0; k < 2; k++) step(1'b1, 1'b0);

    // alternating enable
    for (int k = 0; k < 10; k++) step(k[0], 1'b0);

    // async reset mid run (R1)
    @(negedge clk); cnt_en = 1'b1; rst_ni = 1'b0; #1;
    chk("R1 async reset", state_o, '0);
    @(posedge clk); #1;
    chk("R1 held in reset", state_o, '0);
    @(negedge clk); rst_ni = 1'b1; cnt_en = 1'b0;
    model = '0;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule